// File: doc/BRIEF.md
# Emulation Break Condition Unit

This unit sits beside a 4-bit target CPU inside an in-circuit emulator. Every cycle it looks at the instruction fetch address, the data-memory access, the register file after each retired instruction and a handful of external strobes. It then decides whether the running target program must stop. When a source is hit, the unit raises `brk_req` in the same cycle and enters a break state. It latches a cause code and pulls the active-low stop status output low. The break state lasts until the host starts a new run.

Four comparator classes can each be switched on by the host:
- a per-address program-counter bitmap;
- a three-step ordered PC sequence with a pass count on its last step;
- a data-access window with bit masks;
- a masked register-value match.

Their results are ORed. A host forced break, a falling edge on the external break pin and three memory-map checks are always armed while the program runs. The map checks are an access outside the implemented map, a write into a protected window and a stack access outside the stack window. The unit also blocks protected writes at the memory write enable. It holds off any break while an interrupt acknowledge is in progress, so a break that coincides with an interrupt stops the program at the first handler instruction.

The host programs the unit through a plain synchronous write port: `cfg_we`, a 5-bit register index and 16 bits of data. The unit has no streaming interface; every pin is a level or single-cycle strobe.

Top module: `brk_unit`

## Requirements
- R1: With enable bit 0 of register 0 set, a fetch (`fetch_vld`) of an address whose bitmap bit is 1 raises `brk_req` in that same cycle, before the instruction runs. Writing register 21 sets (`cfg_wdata[15]`=1) or clears (`cfg_wdata[15]`=0) the bitmap bit indexed by `cfg_wdata[7:0]`. Unmarked addresses never break.
- R2: With enable bit 1 set, a break fires only after fetches of address 1 (reg 1), then address 2 (reg 2), then address 3 (reg 3), in that order. Address 3 must be fetched N times after address 2, where N is register 4 bits [7:0]. A count of 0 acts as 1.
- R3: The sequence returns to its first step at every `run_start`. A non-matching fetch leaves the progress unchanged. A fetch of address 1 at any step restarts the sequence and zeroes the pass count.
- R4: With enable bit 2 set, a data access (`mem_vld`) breaks in its own cycle when all of the following hold:
  - the address lies within [reg 5, reg 6] inclusive;
  - `mem_data` equals reg 7 bits [3:0] on the bits set in reg 7 bits [7:4];
  - `mem_wr` equals reg 7 bit 8 when reg 7 bit 9 is 1.
- R5: With enable bit 3 set, a `retire_vld` cycle breaks when every register agrees with its value on the bits set in its mask. Each of registers 8 (A), 9 (B) and 12 (flags) holds value in [3:0] and mask in [7:4]. Each of registers 10 (X) and 11 (Y) holds value in [7:0] and mask in [15:8].
- R6: The four comparator classes are ORed: any enabled class hitting causes a break. A class whose enable bit is 0 never causes a break.
- R7: While running, a falling edge of `brk_pin_n` (high on the previous clock, low now) breaks. `host_brk` also breaks.
- R8: The following break:
  - a fetch above the ROM top (reg 15);
  - a data access above the RAM top (reg 16) that is not inside the I/O window [reg 17, reg 18].
- R9: A write into the protected window [reg 19, reg 20] drives `mem_wr_en` low, whether or not the program runs, and breaks while running. Reads there do not break.
- R10: A stack access (`stack_acc` with `mem_vld`) outside [reg 13, reg 14] breaks.
- R11: While `intack_n` is low, `brk_req` stays low. A hit seen then is held and fires in the first cycle with `intack_n` high.
- R12: `brk_cause` latches the code of the break that fired. When several sources fire in one cycle, the lowest code wins. The codes are 1 host, 2 pin, 3 undefined, 4 protect, 5 stack, 6 PC bitmap, 7 sequence, 8 data and 9 register. The code holds until `run_start`, which clears it to 0 and leaves the break state.
- R13: `stop_n` is low while `halted` is high or the unit is in break, and high otherwise.
- R14: No source raises `brk_req` while `running` is low or the unit is already in break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Host register write strobe |
| cfg_addr | input | 5 | Host register index |
| cfg_wdata | input | 16 | Host write data |
| run_start | input | 1 | Host starts a run; clears break state and sequence |
| running | input | 1 | Target program is executing |
| halted | input | 1 | CPU is in halt or sleep |
| intack_n | input | 1 | Interrupt acknowledge, active low |
| brk_pin_n | input | 1 | External break pin, falling edge active |
| host_brk | input | 1 | Host forced break |
| fetch_vld | input | 1 | Instruction fetch this cycle |
| fetch_pc | input | 8 | Fetch address |
| retire_vld | input | 1 | Instruction retired; register ports valid |
| reg_a | input | 4 | CPU register A |
| reg_b | input | 4 | CPU register B |
| reg_x | input | 8 | CPU register X |
| reg_y | input | 8 | CPU register Y |
| reg_flags | input | 4 | CPU flags E/I/C/Z |
| mem_vld | input | 1 | Data access this cycle |
| mem_wr | input | 1 | Data access is a write |
| stack_acc | input | 1 | Data access is a stack operation |
| mem_addr | input | 8 | Data access address |
| mem_data | input | 4 | Data read or written |
| mem_wr_en | output | 1 | Write enable passed to memory |
| brk_req | output | 1 | Break request, same cycle as the hit |
| brk_cause | output | 4 | Latched cause code |
| stop_n | output | 1 | Low while halted or in break |

## Verification
The sequential comparator is driven with the addresses in order, out of order, with unrelated fetches in between and with a mid-sequence restart on address 1. This separates a design that resets on a mismatch or ignores ordering from one that tracks progress correctly, and a pass count of 0 is tried against one of 2.

Data and register comparators get stimulus that differs only on masked bits and stimulus that differs on compared bits, which shows whether the masks are honoured. Window checks are probed just inside and just outside each bound.

Simultaneous host and pin breaks show the priority order. An interrupt acknowledge that overlaps a hit shows that the break is postponed rather than lost.

// File: rtl/brk_pkg.sv
`timescale 1ns/1ps
package brk_pkg;
  localparam int CFG_AW  = 5;
  localparam int CAUSE_W = 4;
  localparam int NSRC    = 9;

  // register indices
  localparam logic [CFG_AW-1:0] RG_CTL    = 5'd0;
  localparam logic [CFG_AW-1:0] RG_SEQ1   = 5'd1;
  localparam logic [CFG_AW-1:0] RG_SEQ2   = 5'd2;
  localparam logic [CFG_AW-1:0] RG_SEQ3   = 5'd3;
  localparam logic [CFG_AW-1:0] RG_PASS   = 5'd4;
  localparam logic [CFG_AW-1:0] RG_DLO    = 5'd5;
  localparam logic [CFG_AW-1:0] RG_DHI    = 5'd6;
  localparam logic [CFG_AW-1:0] RG_DCMP   = 5'd7;
  localparam logic [CFG_AW-1:0] RG_RA     = 5'd8;
  localparam logic [CFG_AW-1:0] RG_RB     = 5'd9;
  localparam logic [CFG_AW-1:0] RG_RX     = 5'd10;
  localparam logic [CFG_AW-1:0] RG_RY     = 5'd11;
  localparam logic [CFG_AW-1:0] RG_RF     = 5'd12;
  localparam logic [CFG_AW-1:0] RG_STKLO  = 5'd13;
  localparam logic [CFG_AW-1:0] RG_STKHI  = 5'd14;
  localparam logic [CFG_AW-1:0] RG_ROMTOP = 5'd15;
  localparam logic [CFG_AW-1:0] RG_RAMTOP = 5'd16;
  localparam logic [CFG_AW-1:0] RG_IOLO   = 5'd17;
  localparam logic [CFG_AW-1:0] RG_IOHI   = 5'd18;
  localparam logic [CFG_AW-1:0] RG_PLO    = 5'd19;
  localparam logic [CFG_AW-1:0] RG_PHI    = 5'd20;
  localparam logic [CFG_AW-1:0] RG_BITMAP = 5'd21;

  // source index = priority (0 highest); cause code = index + 1
  localparam int SRC_HOST  = 0;
  localparam int SRC_PIN   = 1;
  localparam int SRC_UNDEF = 2;
  localparam int SRC_PROT  = 3;
  localparam int SRC_STACK = 4;
  localparam int SRC_PC    = 5;
  localparam int SRC_SEQ   = 6;
  localparam int SRC_DATA  = 7;
  localparam int SRC_REG   = 8;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE = 4'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_PROT = 4'd4;
endpackage

// File: rtl/brk_cfg_regs.sv
`timescale 1ns/1ps
module brk_cfg_regs
  import brk_pkg::*;
#(
  parameter int PC_W = 8,
  parameter int DA_W = 8,
  parameter int DW   = 4,
  parameter int XW   = 8,
  parameter int FW   = 4,
  parameter int CW   = 16,
  parameter int PW   = 8,
  localparam int RV_W  = 2*DW + 2*XW + FW,
  localparam int NADDR = 1 << PC_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CW-1:0]     cfg_wdata,
  output logic [3:0]        en,
  output logic [PC_W-1:0]   seq_a1,
  output logic [PC_W-1:0]   seq_a2,
  output logic [PC_W-1:0]   seq_a3,
  output logic [PW-1:0]     seq_pass,
  output logic [DA_W-1:0]   d_lo,
  output logic [DA_W-1:0]   d_hi,
  output logic [DW-1:0]     d_val,
  output logic [DW-1:0]     d_mask,
  output logic              rw_val,
  output logic              rw_mask,
  output logic [RV_W-1:0]   rv_val,
  output logic [RV_W-1:0]   rv_mask,
  output logic [DA_W-1:0]   stk_lo,
  output logic [DA_W-1:0]   stk_hi,
  output logic [PC_W-1:0]   rom_top,
  output logic [DA_W-1:0]   ram_top,
  output logic [DA_W-1:0]   io_lo,
  output logic [DA_W-1:0]   io_hi,
  output logic [DA_W-1:0]   prot_lo,
  output logic [DA_W-1:0]   prot_hi,
  output logic [NADDR-1:0]  bitmap
);
  logic [DW-1:0] ra_v, ra_m, rb_v, rb_m;
  logic [XW-1:0] rx_v, rx_m, ry_v, ry_m;
  logic [FW-1:0] rf_v, rf_m;

  assign rv_val  = {ra_v, rb_v, rx_v, ry_v, rf_v};
  assign rv_mask = {ra_m, rb_m, rx_m, ry_m, rf_m};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= '0; seq_a1 <= '0; seq_a2 <= '0; seq_a3 <= '0; seq_pass <= '0;
      d_lo <= '0; d_hi <= '0; d_val <= '0; d_mask <= '0;
      rw_val <= 1'b0; rw_mask <= 1'b0;
      ra_v <= '0; ra_m <= '0; rb_v <= '0; rb_m <= '0;
      rx_v <= '0; rx_m <= '0; ry_v <= '0; ry_m <= '0;
      rf_v <= '0; rf_m <= '0;
      stk_lo <= '0; stk_hi <= '1;
      rom_top <= '1; ram_top <= '1;
      io_lo <= '1; io_hi <= '0;
      prot_lo <= '1; prot_hi <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        RG_CTL:    en       <= cfg_wdata[3:0];
        RG_SEQ1:   seq_a1   <= cfg_wdata[PC_W-1:0];
        RG_SEQ2:   seq_a2   <= cfg_wdata[PC_W-1:0];
        RG_SEQ3:   seq_a3   <= cfg_wdata[PC_W-1:0];
        RG_PASS:   seq_pass <= cfg_wdata[PW-1:0];
        RG_DLO:    d_lo     <= cfg_wdata[DA_W-1:0];
        RG_DHI:    d_hi     <= cfg_wdata[DA_W-1:0];
        RG_DCMP: begin
          d_val   <= cfg_wdata[DW-1:0];
          d_mask  <= cfg_wdata[2*DW-1:DW];
          rw_val  <= cfg_wdata[2*DW];
          rw_mask <= cfg_wdata[2*DW+1];
        end
        RG_RA: begin ra_v <= cfg_wdata[DW-1:0]; ra_m <= cfg_wdata[2*DW-1:DW]; end
        RG_RB: begin rb_v <= cfg_wdata[DW-1:0]; rb_m <= cfg_wdata[2*DW-1:DW]; end
        RG_RX: begin rx_v <= cfg_wdata[XW-1:0]; rx_m <= cfg_wdata[2*XW-1:XW]; end
        RG_RY: begin ry_v <= cfg_wdata[XW-1:0]; ry_m <= cfg_wdata[2*XW-1:XW]; end
        RG_RF: begin rf_v <= cfg_wdata[FW-1:0]; rf_m <= cfg_wdata[2*FW-1:FW]; end
        RG_STKLO:  stk_lo  <= cfg_wdata[DA_W-1:0];
        RG_STKHI:  stk_hi  <= cfg_wdata[DA_W-1:0];
        RG_ROMTOP: rom_top <= cfg_wdata[PC_W-1:0];
        RG_RAMTOP: ram_top <= cfg_wdata[DA_W-1:0];
        RG_IOLO:   io_lo   <= cfg_wdata[DA_W-1:0];
        RG_IOHI:   io_hi   <= cfg_wdata[DA_W-1:0];
        RG_PLO:    prot_lo <= cfg_wdata[DA_W-1:0];
        RG_PHI:    prot_hi <= cfg_wdata[DA_W-1:0];
        default: ;
      endcase
    end
  end

  // one flop per program address; written one bit at a time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bitmap <= '0;
    else if (cfg_we && cfg_addr == RG_BITMAP)
      bitmap[cfg_wdata[PC_W-1:0]] <= cfg_wdata[CW-1];
  end

  // R1: a bitmap write lands on the indexed bit
  p_bitmap_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == RG_BITMAP) |=>
      (bitmap[$past(cfg_wdata[PC_W-1:0])] == $past(cfg_wdata[CW-1])));
endmodule

// File: rtl/brk_seq_tracker.sv
`timescale 1ns/1ps
module brk_seq_tracker #(
  parameter int PC_W = 8,
  parameter int PW   = 8
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            adv_en,
  input  logic            fetch_vld,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic [PC_W-1:0] a1,
  input  logic [PC_W-1:0] a2,
  input  logic [PC_W-1:0] a3,
  input  logic [PW-1:0]   pass,
  output logic            hit
);
  typedef enum logic [1:0] {S_WAIT1, S_WAIT2, S_COUNT} seq_st_e;

  seq_st_e       st_q;
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] pass_eff;
  logic [PW:0]   cnt_inc;
  logic          step;
  logic          m1, m2, m3;

  assign pass_eff = (pass == '0) ? PW'(1) : pass;
  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign step     = adv_en && fetch_vld;
  assign m1       = fetch_pc == a1;
  assign m2       = fetch_pc == a2;
  assign m3       = fetch_pc == a3;
  assign hit      = step && !m1 && (st_q == S_COUNT) && m3 &&
                    (cnt_inc >= {1'b0, pass_eff});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_WAIT1;
      cnt_q <= '0;
    end else if (clr) begin
      st_q  <= S_WAIT1;
      cnt_q <= '0;
    end else if (step) begin
      if (m1) begin
        st_q  <= S_WAIT2;
        cnt_q <= '0;
      end else if (st_q == S_WAIT2 && m2) begin
        st_q  <= S_COUNT;
        cnt_q <= '0;
      end else if (st_q == S_COUNT && m3 && cnt_q != '1) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2: the sequence can only fire from its last step
  p_seq_last_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (st_q == S_COUNT));
  // R3: a restart request always returns to the first step
  p_seq_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (st_q == S_WAIT1 && cnt_q == '0));
endmodule

// File: rtl/brk_match.sv
`timescale 1ns/1ps
module brk_match #(
  parameter int PC_W = 8,
  parameter int DA_W = 8,
  parameter int DW   = 4,
  parameter int RV_W = 28,
  localparam int NADDR = 1 << PC_W
)(
  input  logic             fetch_vld,
  input  logic [PC_W-1:0]  fetch_pc,
  input  logic             mem_vld,
  input  logic             mem_wr,
  input  logic             stack_acc,
  input  logic [DA_W-1:0]  mem_addr,
  input  logic [DW-1:0]    mem_data,
  input  logic             retire_vld,
  input  logic [RV_W-1:0]  cpu_regs,
  input  logic [NADDR-1:0] bitmap,
  input  logic [DA_W-1:0]  d_lo,
  input  logic [DA_W-1:0]  d_hi,
  input  logic [DW-1:0]    d_val,
  input  logic [DW-1:0]    d_mask,
  input  logic             rw_val,
  input  logic             rw_mask,
  input  logic [RV_W-1:0]  rv_val,
  input  logic [RV_W-1:0]  rv_mask,
  input  logic [DA_W-1:0]  stk_lo,
  input  logic [DA_W-1:0]  stk_hi,
  input  logic [PC_W-1:0]  rom_top,
  input  logic [DA_W-1:0]  ram_top,
  input  logic [DA_W-1:0]  io_lo,
  input  logic [DA_W-1:0]  io_hi,
  input  logic [DA_W-1:0]  prot_lo,
  input  logic [DA_W-1:0]  prot_hi,
  output logic             pc_hit,
  output logic             data_hit,
  output logic             reg_hit,
  output logic             undef_hit,
  output logic             prot_hit,
  output logic             stack_hit,
  output logic             in_prot
);
  logic in_io, in_drange, data_eq, rw_eq;

  assign in_io     = (mem_addr >= io_lo) && (mem_addr <= io_hi);
  assign in_prot   = (mem_addr >= prot_lo) && (mem_addr <= prot_hi);
  assign in_drange = (mem_addr >= d_lo) && (mem_addr <= d_hi);
  assign data_eq   = ((mem_data ^ d_val) & d_mask) == '0;
  assign rw_eq     = !rw_mask || (mem_wr == rw_val);

  assign pc_hit    = fetch_vld && bitmap[fetch_pc];
  assign data_hit  = mem_vld && in_drange && data_eq && rw_eq;
  assign reg_hit   = retire_vld && (((cpu_regs ^ rv_val) & rv_mask) == '0);
  assign undef_hit = (fetch_vld && (fetch_pc > rom_top)) ||
                     (mem_vld && (mem_addr > ram_top) && !in_io);
  assign prot_hit  = mem_vld && mem_wr && in_prot;
  assign stack_hit = mem_vld && stack_acc &&
                     ((mem_addr < stk_lo) || (mem_addr > stk_hi));
endmodule

// File: rtl/brk_unit.sv
`timescale 1ns/1ps
module brk_unit
  import brk_pkg::*;
#(
  parameter int PC_W = 8,
  parameter int DA_W = 8,
  parameter int DW   = 4,
  parameter int XW   = 8,
  parameter int FW   = 4,
  parameter int CW   = 16,
  parameter int PW   = 8,
  localparam int RV_W  = 2*DW + 2*XW + FW,
  localparam int NADDR = 1 << PC_W
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [CW-1:0]      cfg_wdata,
  input  logic               run_start,
  input  logic               running,
  input  logic               halted,
  input  logic               intack_n,
  input  logic               brk_pin_n,
  input  logic               host_brk,
  input  logic               fetch_vld,
  input  logic [PC_W-1:0]    fetch_pc,
  input  logic               retire_vld,
  input  logic [DW-1:0]      reg_a,
  input  logic [DW-1:0]      reg_b,
  input  logic [XW-1:0]      reg_x,
  input  logic [XW-1:0]      reg_y,
  input  logic [FW-1:0]      reg_flags,
  input  logic               mem_vld,
  input  logic               mem_wr,
  input  logic               stack_acc,
  input  logic [DA_W-1:0]    mem_addr,
  input  logic [DW-1:0]      mem_data,
  output logic               mem_wr_en,
  output logic               brk_req,
  output logic [CAUSE_W-1:0] brk_cause,
  output logic               stop_n
);
  logic [3:0]        en;
  logic [PC_W-1:0]   seq_a1, seq_a2, seq_a3, rom_top;
  logic [PW-1:0]     seq_pass;
  logic [DA_W-1:0]   d_lo, d_hi, stk_lo, stk_hi, ram_top, io_lo, io_hi, prot_lo, prot_hi;
  logic [DW-1:0]     d_val, d_mask;
  logic              rw_val, rw_mask;
  logic [RV_W-1:0]   rv_val, rv_mask, cpu_regs;
  logic [NADDR-1:0]  bitmap;

  logic pc_hit, data_hit, reg_hit, undef_hit, prot_hit, stack_hit, in_prot, seq_hit;
  logic pin_q, pin_fall, armed;
  logic in_break_q, pend_q;
  logic [CAUSE_W-1:0] pend_code_q, cause_q, hit_code, nxt_code;
  logic [NSRC-1:0]    raw, hits;
  logic               any_hit, fire;

  assign cpu_regs = {reg_a, reg_b, reg_x, reg_y, reg_flags};

  brk_cfg_regs #(.PC_W(PC_W), .DA_W(DA_W), .DW(DW), .XW(XW), .FW(FW), .CW(CW), .PW(PW))
  u_cfg (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .en, .seq_a1, .seq_a2, .seq_a3, .seq_pass,
    .d_lo, .d_hi, .d_val, .d_mask, .rw_val, .rw_mask,
    .rv_val, .rv_mask, .stk_lo, .stk_hi, .rom_top, .ram_top,
    .io_lo, .io_hi, .prot_lo, .prot_hi, .bitmap
  );

  brk_match #(.PC_W(PC_W), .DA_W(DA_W), .DW(DW), .RV_W(RV_W)) u_match (
    .fetch_vld, .fetch_pc, .mem_vld, .mem_wr, .stack_acc, .mem_addr, .mem_data,
    .retire_vld, .cpu_regs, .bitmap,
    .d_lo, .d_hi, .d_val, .d_mask, .rw_val, .rw_mask, .rv_val, .rv_mask,
    .stk_lo, .stk_hi, .rom_top, .ram_top, .io_lo, .io_hi, .prot_lo, .prot_hi,
    .pc_hit, .data_hit, .reg_hit, .undef_hit, .prot_hit, .stack_hit, .in_prot
  );

  assign armed = running && !in_break_q;

  brk_seq_tracker #(.PC_W(PC_W), .PW(PW)) u_seq (
    .clk, .rst_n, .clr(run_start), .adv_en(armed && en[1]),
    .fetch_vld, .fetch_pc, .a1(seq_a1), .a2(seq_a2), .a3(seq_a3),
    .pass(seq_pass), .hit(seq_hit)
  );

  // external pin edge detector
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b1;
    else        pin_q <= brk_pin_n;
  end
  assign pin_fall = pin_q && !brk_pin_n;

  // raw source vector in priority order
  always_comb begin
    raw            = '0;
    raw[SRC_HOST]  = host_brk;
    raw[SRC_PIN]   = pin_fall;
    raw[SRC_UNDEF] = undef_hit;
    raw[SRC_PROT]  = prot_hit;
    raw[SRC_STACK] = stack_hit;
    raw[SRC_PC]    = pc_hit   && en[0];
    raw[SRC_SEQ]   = seq_hit;
    raw[SRC_DATA]  = data_hit && en[2];
    raw[SRC_REG]   = reg_hit  && en[3];
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    assign hits[g] = raw[g] && armed;
  end

  always_comb begin
    hit_code = CAUSE_NONE;
    for (int i = NSRC - 1; i >= 0; i--)
      if (hits[i]) hit_code = CAUSE_W'(i + 1);
  end

  assign any_hit   = |hits;
  assign fire      = armed && intack_n && (any_hit || pend_q);
  assign nxt_code  = pend_q ? pend_code_q : hit_code;
  assign brk_req   = fire;
  assign brk_cause = cause_q;
  assign stop_n    = !(halted || in_break_q);
  assign mem_wr_en = mem_vld && mem_wr && !in_prot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_break_q  <= 1'b0;
      cause_q     <= CAUSE_NONE;
      pend_q      <= 1'b0;
      pend_code_q <= CAUSE_NONE;
    end else if (run_start) begin
      in_break_q  <= 1'b0;
      cause_q     <= CAUSE_NONE;
      pend_q      <= 1'b0;
      pend_code_q <= CAUSE_NONE;
    end else if (fire) begin
      in_break_q  <= 1'b1;
      cause_q     <= nxt_code;
      pend_q      <= 1'b0;
    end else if (armed && !intack_n && any_hit && !pend_q) begin
      pend_q      <= 1'b1;
      pend_code_q <= hit_code;
    end
  end

  // R11: nothing breaks during an interrupt acknowledge
  p_no_brk_in_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !intack_n |-> !brk_req);
  // R11: a held hit fires as soon as the acknowledge ends
  p_pend_fires_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && intack_n && running && !run_start) |-> brk_req);
  // R13: stop status is low during break
  p_stop_in_break_r13: assert property (@(posedge clk) disable iff (!rst_n)
    in_break_q |-> !stop_n);
  // R9: a protect break never lets the write through
  p_prot_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && !pend_q && hit_code == CAUSE_PROT) |-> !mem_wr_en);
  // R12: cause holds for the whole break
  p_cause_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_break_q && !run_start) |=> ($stable(brk_cause) && brk_cause != CAUSE_NONE));
  // R12: restart clears the cause
  p_restart_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> (brk_cause == CAUSE_NONE && stop_n == !halted));
  // R14: no request while stopped or already broken
  p_idle_quiet_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (!running || in_break_q) |-> !brk_req);
endmodule

// File: tb/test_brk_unit.sv
`timescale 1ns/1ps
module test_brk_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        run_start = 1'b0, running = 1'b0, halted = 1'b0;
  logic        intack_n = 1'b1, brk_pin_n = 1'b1, host_brk = 1'b0;
  logic        fetch_vld = 1'b0;
  logic [7:0]  fetch_pc = '0;
  logic        retire_vld = 1'b0;
  logic [3:0]  reg_a = '0, reg_b = '0, reg_flags = '0;
  logic [7:0]  reg_x = '0, reg_y = '0;
  logic        mem_vld = 1'b0, mem_wr = 1'b0, stack_acc = 1'b0;
  logic [7:0]  mem_addr = '0;
  logic [3:0]  mem_data = '0;
  logic        mem_wr_en, brk_req, stop_n;
  logic [3:0]  brk_cause;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  brk_unit i_brk_unit (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .run_start, .running, .halted,
    .intack_n, .brk_pin_n, .host_brk, .fetch_vld, .fetch_pc, .retire_vld,
    .reg_a, .reg_b, .reg_x, .reg_y, .reg_flags, .mem_vld, .mem_wr, .stack_acc,
    .mem_addr, .mem_data, .mem_wr_en, .brk_req, .brk_cause, .stop_n
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; running = 1'b0; halted = 1'b0; intack_n = 1'b1;
    brk_pin_n = 1'b1; host_brk = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start_run();
    run_start = 1'b1; running = 1'b1;
    @(negedge clk);
    run_start = 1'b0;
  endtask

  // stimulus already applied; check request, advance, clear strobes
  task automatic tick(input string tag, input logic exp_req);
    #1 chk(tag, brk_req, exp_req);
    @(negedge clk);
    fetch_vld = 1'b0; mem_vld = 1'b0; retire_vld = 1'b0;
    stack_acc = 1'b0; host_brk = 1'b0; mem_wr = 1'b0;
  endtask

  task automatic fetch(input string tag, input logic [7:0] pc, input logic exp_req);
    fetch_vld = 1'b1; fetch_pc = pc;
    tick(tag, exp_req);
  endtask

  task automatic access(input string tag, input logic [7:0] a, input logic w,
                        input logic [3:0] d, input logic stk, input logic exp_req);
    mem_vld = 1'b1; mem_addr = a; mem_wr = w; mem_data = d; stack_acc = stk;
    tick(tag, exp_req);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12 reset cause", brk_cause, 4'd0);
    chk("R13 reset stop_n", stop_n, 1'b1);
    chk("R14 reset no req", brk_req, 1'b0);
  endtask

  task automatic t_pc_bitmap();
    do_reset();
    wr(5'd0, 16'h0001);
    wr(5'd21, 16'h8040);
    start_run();
    fetch("R1 unmarked", 8'h41, 1'b0);
    fetch("R1 marked", 8'h40, 1'b1);
    chk("R12 pc cause", brk_cause, 4'd6);
    chk("R13 stop in break", stop_n, 1'b0);
    fetch("R14 in break", 8'h40, 1'b0);
    wr(5'd21, 16'h0040);
    start_run();
    chk("R12 cleared", brk_cause, 4'd0);
    fetch("R1 cleared bit", 8'h40, 1'b0);
  endtask

  task automatic t_sequence();
    do_reset();
    wr(5'd0, 16'h0002);
    wr(5'd1, 16'd10); wr(5'd2, 16'd20); wr(5'd3, 16'd30); wr(5'd4, 16'd2);
    start_run();
    fetch("R2 a3 first", 8'd30, 1'b0);
    fetch("R2 a2 first", 8'd20, 1'b0);
    fetch("R2 a1", 8'd10, 1'b0);
    fetch("R3 mismatch", 8'd55, 1'b0);
    fetch("R2 a2", 8'd20, 1'b0);
    fetch("R2 a3 count1", 8'd30, 1'b0);
    fetch("R3 restart a1", 8'd10, 1'b0);
    fetch("R3 a3 after restart", 8'd30, 1'b0);
    fetch("R2 a2 again", 8'd20, 1'b0);
    fetch("R2 a3 count1b", 8'd30, 1'b0);
    fetch("R2 a3 count2", 8'd30, 1'b1);
    chk("R12 seq cause", brk_cause, 4'd7);
    wr(5'd4, 16'd0);
    start_run();
    fetch("R3 a1", 8'd10, 1'b0);
    fetch("R3 a2", 8'd20, 1'b0);
    start_run();
    fetch("R3 run_start reset", 8'd30, 1'b0);
    fetch("R3 a1 b", 8'd10, 1'b0);
    fetch("R2 a2 b", 8'd20, 1'b0);
    fetch("R2 pass0", 8'd30, 1'b1);
  endtask

  task automatic t_data();
    do_reset();
    wr(5'd5, 16'h0020); wr(5'd6, 16'h002F);
    wr(5'd7, 16'h0375);
    wr(5'd0, 16'h0004);
    start_run();
    access("R4 out of range", 8'h30, 1'b1, 4'h5, 1'b0, 1'b0);
    access("R4 wrong dir", 8'h25, 1'b0, 4'h5, 1'b0, 1'b0);
    access("R4 cared bit", 8'h25, 1'b1, 4'h4, 1'b0, 1'b0);
    access("R4 low bound", 8'h20, 1'b1, 4'hD, 1'b0, 1'b1);
    chk("R12 data cause", brk_cause, 4'd8);
  endtask

  task automatic t_register();
    do_reset();
    wr(5'd8, 16'h00F3);
    wr(5'd10, 16'hF080);
    wr(5'd0, 16'h0008);
    start_run();
    retire_vld = 1'b1; reg_a = 4'd2; reg_x = 8'h80;
    tick("R5 A differs", 1'b0);
    retire_vld = 1'b1; reg_a = 4'd3; reg_x = 8'h7F;
    tick("R5 X high nibble differs", 1'b0);
    retire_vld = 1'b1; reg_a = 4'd3; reg_x = 8'h8F; reg_b = 4'd9;
    tick("R5 masked match", 1'b1);
    chk("R12 reg cause", brk_cause, 4'd9);
  endtask

  task automatic t_or_enable();
    do_reset();
    wr(5'd21, 16'h8040);
    wr(5'd5, 16'h0020); wr(5'd6, 16'h002F); wr(5'd7, 16'h0000);
    wr(5'd0, 16'h0004);
    start_run();
    fetch("R6 pc disabled", 8'h40, 1'b0);
    wr(5'd0, 16'h0005);
    access("R6 data with pc on", 8'h22, 1'b0, 4'h0, 1'b0, 1'b1);
    chk("R6 cause data", brk_cause, 4'd8);
    start_run();
    fetch("R6 pc with data on", 8'h40, 1'b1);
  endtask

  task automatic t_pin_host();
    do_reset();
    brk_pin_n = 1'b0;
    tick("R14 pin not running", 1'b0);
    host_brk = 1'b1;
    tick("R14 host not running", 1'b0);
    brk_pin_n = 1'b1;
    start_run();
    brk_pin_n = 1'b0;
    tick("R7 pin fall", 1'b1);
    chk("R7 pin cause", brk_cause, 4'd2);
    brk_pin_n = 1'b1;
    start_run();
    brk_pin_n = 1'b0;
    host_brk  = 1'b1;
    tick("R7 host", 1'b1);
    chk("R12 host beats pin", brk_cause, 4'd1);
    brk_pin_n = 1'b1;
  endtask

  task automatic t_undefined();
    do_reset();
    wr(5'd15, 16'h007F);
    wr(5'd16, 16'h003F); wr(5'd17, 16'h00F0); wr(5'd18, 16'h00FF);
    start_run();
    fetch("R8 rom top", 8'h7F, 1'b0);
    fetch("R8 above rom", 8'h80, 1'b1);
    chk("R8 cause", brk_cause, 4'd3);
    start_run();
    access("R8 ram top", 8'h3F, 1'b0, 4'h0, 1'b0, 1'b0);
    access("R8 io window", 8'hF5, 1'b0, 4'h0, 1'b0, 1'b0);
    access("R8 hole", 8'h50, 1'b0, 4'h0, 1'b0, 1'b1);
    chk("R8 data cause", brk_cause, 4'd3);
  endtask

  task automatic t_protect();
    do_reset();
    wr(5'd19, 16'h0010); wr(5'd20, 16'h001F);
    mem_vld = 1'b1; mem_addr = 8'h12; mem_wr = 1'b1;
    #1 chk("R9 blocked idle", mem_wr_en, 1'b0);
    tick("R9 no break idle", 1'b0);
    start_run();
    access("R9 read inside", 8'h12, 1'b0, 4'h1, 1'b0, 1'b0);
    mem_vld = 1'b1; mem_addr = 8'h20; mem_wr = 1'b1;
    #1 chk("R9 outside write passes", mem_wr_en, 1'b1);
    tick("R9 outside no break", 1'b0);
    mem_vld = 1'b1; mem_addr = 8'h1F; mem_wr = 1'b1;
    #1 chk("R9 top bound blocked", mem_wr_en, 1'b0);
    tick("R9 protect break", 1'b1);
    chk("R9 cause", brk_cause, 4'd4);
  endtask

  task automatic t_stack();
    do_reset();
    wr(5'd13, 16'h0030); wr(5'd14, 16'h003F);
    start_run();
    access("R10 plain access", 8'h2F, 1'b0, 4'h0, 1'b0, 1'b0);
    access("R10 inside", 8'h30, 1'b1, 4'h0, 1'b1, 1'b0);
    access("R10 below", 8'h2F, 1'b1, 4'h0, 1'b1, 1'b1);
    chk("R10 cause", brk_cause, 4'd5);
  endtask

  task automatic t_intack();
    do_reset();
    wr(5'd0, 16'h0001);
    wr(5'd21, 16'h8040);
    start_run();
    intack_n = 1'b0;
    fetch("R11 held in ack", 8'h40, 1'b0);
    chk("R11 not in break", stop_n, 1'b1);
    intack_n = 1'b1;
    fetch("R11 fires at handler", 8'h50, 1'b1);
    chk("R11 cause kept", brk_cause, 4'd6);
  endtask

  task automatic t_stop();
    do_reset();
    start_run();
    halted = 1'b1;
    #1 chk("R13 halted", stop_n, 1'b0);
    @(negedge clk);
    halted = 1'b0;
    #1 chk("R13 running", stop_n, 1'b1);
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_pc_bitmap();
    t_sequence();
    t_data();
    t_register();
    t_or_enable();
    t_pin_host();
    t_undefined();
    t_protect();
    t_stack();
    t_intack();
    t_stop();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule